// File: doc/BRIEF.md
# Pin Change Reporter with SPI Readout

This block watches a wide set of digital inputs, organised as ports of sixteen pins, and tells an external master which pins have toggled. A scan sequencer visits one port per clock in a continuous loop and compares it with a stored reference copy of that port. When a port differs from its reference, the block captures a report holding the number of changed pins and the indices of the two lowest changed pins. It then raises an interrupt line towards the master.

The master fetches the report by clocking out a 32-bit frame over an SPI mode 0 slave interface. The block uses that read as the acknowledgement. Until a complete read has ended, scanning is frozen, the reference copies are left alone and the pending report cannot be overwritten. A change that arrives while the block waits is therefore not lost: it still differs from the reference once scanning resumes, and it produces the next report.

Inside the block, the scan sequencer offers each report on a valid/ready link to the SPI shifter. `valid` stays high, and drives the interrupt, until the shifter pulses `ready` for one clock after a complete read. While the report has not been taken, the sequencer applies back-pressure by stopping its scan. Pins, SCLK and chip select are asynchronous to `clk` and each passes through a two-flop synchroniser. SCLK must therefore run well below the system clock: each SCLK phase must last at least four `clk` periods.

Top module: `change_report_spi`

## Requirements
- R1: After reset, `irq` and `spi_miso` are low. The first pass over all ports loads the reference copies without reporting, so levels that are already present at reset raise no interrupt.
- R2: Ports are compared one per clock in ascending order, wrapping after the last port. Any difference between a port and its reference raises `irq`.
- R3: The frame is 32 bits and is sent MSB first. Bits [31:30] hold the change count, bits [29:20] the lower changed pin index, bits [19:10] the higher changed pin index, and bits [9:0] are zero. A pin index is port*16 + bit.
- R4: The change count is 1 when one pin of the port changed, with the higher index field zero. It is 2 when two pins changed. It is 3 when more than two changed; the two lowest indices are then reported.
- R5: While `irq` is high, no port is compared and no reference changes. A change made during that wait is reported after the acknowledgement. Scanning resumes at the port after the one that was reported.
- R6: A rising `spi_cs_n` after at least 32 rising SCLK edges acknowledges the report and clears `irq`. A read with fewer edges leaves `irq` high, and the same frame can be read again.
- R7: A read while no report is pending returns an all-zero frame and has no effect on the block.
- R8: SPI mode 0: `spi_miso` changes only after a falling SCLK edge or the falling edge of `spi_cs_n`. It is driven low while `spi_cs_n` is high.
- R9: When a report is made, the reference takes the whole current port value. A pin that later returns to its earlier level is reported as a new change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_in | input | NUM_PORTS*PORT_W | Monitored asynchronous inputs; port p occupies bits p*16 +: 16 |
| spi_sclk | input | 1 | SPI serial clock from the master (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_miso | output | 1 | SPI serial data to the master |
| irq | output | 1 | High while a change report is waiting to be read |

## Verification
The bench builds the block with three ports instead of the default eight. An odd port count exercises the wrap of the scan pointer at a value that is not a power of two, and it keeps the time from a toggle to the interrupt short. With three ports the test can place single, double and triple changes on every port, including index 47 at the top of the last port. It can also queue a change on one port while a report from another port is still pending, to show the freeze and the resume order.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int FRAME_W = 32;
  localparam int IDX_W   = 10;
  localparam int CNT_W   = 2;
  localparam int PAD_W   = FRAME_W - CNT_W - 2 * IDX_W;

  typedef enum logic [1:0] {
    SC_PRIME = 2'd0,
    SC_SCAN  = 2'd1,
    SC_HOLD  = 2'd2
  } scan_state_t;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx_lo;
    logic [IDX_W-1:0] idx_hi;
  } report_t;

  function automatic logic [FRAME_W-1:0] to_frame(input report_t r);
    return {r, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/cr_sync.sv
module cr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cr_scan_seq.sv
module cr_scan_seq
  import cr_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] pins_s,
  input  logic                        rpt_ready,
  output logic                        rpt_valid,
  output report_t                     rpt
);
  localparam int PTR_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_PORTS - 1);

  scan_state_t                          state;
  logic [PTR_W-1:0]                     ptr;
  logic [NUM_PORTS-1:0][PORT_W-1:0]     ref_q;
  logic [PORT_W-1:0]                    cur, diff;
  logic [PTR_W-1:0]                     ptr_nx;
  logic [IDX_W-1:0]                     base, lo, hi;
  logic                                 f0, f1, more;
  report_t                              found;

  assign cur    = pins_s[int'(ptr)*PORT_W +: PORT_W];
  assign diff   = cur ^ ref_q[ptr];
  assign ptr_nx = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign base   = IDX_W'(int'(ptr) * PORT_W);

  // lowest two changed bits of the current port
  always_comb begin
    f0 = 1'b0; f1 = 1'b0; more = 1'b0;
    lo = '0;   hi = '0;
    for (int b = 0; b < PORT_W; b++) begin
      if (diff[b]) begin
        if (!f0) begin
          f0 = 1'b1; lo = base + IDX_W'(b);
        end else if (!f1) begin
          f1 = 1'b1; hi = base + IDX_W'(b);
        end else begin
          more = 1'b1;
        end
      end
    end
    found.cnt    = more ? 2'd3 : (f1 ? 2'd2 : 2'd1);
    found.idx_lo = lo;
    found.idx_hi = hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SC_PRIME;
      ptr   <= '0;
      ref_q <= '0;
      rpt   <= '0;
    end else begin
      unique case (state)
        SC_PRIME: begin
          ref_q[ptr] <= cur;
          ptr        <= ptr_nx;
          if (ptr == LAST) state <= SC_SCAN;
        end
        SC_SCAN: begin
          ptr <= ptr_nx;
          if (diff != '0) begin
            ref_q[ptr] <= cur;
            rpt        <= found;
            state      <= SC_HOLD;
          end
        end
        SC_HOLD: if (rpt_ready) state <= SC_SCAN;
        default: state <= SC_PRIME;
      endcase
    end
  end

  assign rpt_valid = (state == SC_HOLD);

  // R5
  ref_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_HOLD) |=> $stable(ref_q));
  // R4
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> (rpt.cnt != 2'd0));
  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NUM_PORTS);
  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && $past(rpt_valid)) |-> $stable(ptr));
endmodule

// File: rtl/cr_spi_tx.sv
module cr_spi_tx
  import cr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               cs_s,
  input  logic               rpt_valid,
  input  logic [FRAME_W-1:0] frame,
  output logic               rpt_ready,
  output logic               miso
);
  localparam int BIT_W = $clog2(FRAME_W + 1);
  localparam logic [BIT_W-1:0] FULL = BIT_W'(FRAME_W);

  logic               sclk_d, cs_d;
  logic [FRAME_W-1:0] sr;
  logic [BIT_W-1:0]   bits;
  logic               cs_rise, cs_fall, sk_rise, sk_fall;

  assign cs_rise = cs_s & ~cs_d;
  assign cs_fall = ~cs_s & cs_d;
  assign sk_rise = sclk_s & ~sclk_d;
  assign sk_fall = ~sclk_s & sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      cs_d      <= 1'b1;
      sr        <= '0;
      bits      <= '0;
      rpt_ready <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      cs_d      <= cs_s;
      rpt_ready <= cs_rise && (bits == FULL) && rpt_valid;
      if (cs_fall) begin
        sr   <= rpt_valid ? frame : '0;
        bits <= '0;
      end else if (!cs_s) begin
        if (sk_rise && bits != FULL) bits <= bits + 1'b1;
        if (sk_fall) sr <= {sr[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign miso = cs_s ? 1'b0 : sr[FRAME_W-1];

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_ready |=> !rpt_ready);
  // R6
  bits_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bits <= FULL);
  // R8
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !miso);
endmodule

// File: rtl/change_report_spi.sv
module change_report_spi
  import cr_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] pins_in,
  input  logic                        spi_sclk,
  input  logic                        spi_cs_n,
  output logic                        spi_miso,
  output logic                        irq
);
  localparam int PIN_W = NUM_PORTS * PORT_W;

  logic [PIN_W-1:0] pins_s;
  logic [1:0]       spi_s;
  logic             rpt_valid, rpt_ready;
  report_t          rpt;

  cr_sync #(.W(PIN_W), .STAGES(2)) u_pin_sync (
    .clk(clk), .d(pins_in), .q(pins_s));

  cr_sync #(.W(2), .STAGES(2)) u_spi_sync (
    .clk(clk), .d({spi_cs_n, spi_sclk}), .q(spi_s));

  cr_scan_seq #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .pins_s(pins_s),
    .rpt_ready(rpt_ready), .rpt_valid(rpt_valid), .rpt(rpt));

  cr_spi_tx u_spi (
    .clk(clk), .rst_n(rst_n), .sclk_s(spi_s[0]), .cs_s(spi_s[1]),
    .rpt_valid(rpt_valid), .frame(to_frame(rpt)),
    .rpt_ready(rpt_ready), .miso(spi_miso));

  assign irq = rpt_valid;

  // R7
  ack_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_ready |-> rpt_valid);
  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rpt_ready));
endmodule

// File: tb/tb_change_report_spi.sv
module tb_change_report_spi;
  localparam int NP = 3;
  localparam int PW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP*PW-1:0] pins = '0;
  logic sclk = 1'b0, cs_n = 1'b1;
  logic miso, irq;

  int n_chk = 0, n_fail = 0, cyc = 0;

  change_report_spi #(.NUM_PORTS(NP), .PORT_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .pins_in(pins), .spi_sclk(sclk),
    .spi_cs_n(cs_n), .spi_miso(miso), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkf(input int cnt, input int lo, input int hi);
    return (32'(cnt) << 30) | (32'(lo) << 20) | (32'(hi) << 10);
  endfunction

  // behavioural reference model
  logic [NP*PW-1:0] m_p1, m_p2;
  logic m_c1, m_c2, m_cd, m_k1, m_k2, m_kd;
  int   m_state, m_ptr, m_bits;
  logic [PW-1:0] m_ref [NP];
  logic [31:0] m_rpt, m_sr;
  logic m_ready;

  function automatic logic [31:0] build(input int port, input logic [PW-1:0] d);
    int n = 0, lo = 0, hi = 0;
    for (int b = 0; b < PW; b++) if (d[b]) begin
      if (n == 0) lo = port*PW + b; else if (n == 1) hi = port*PW + b;
      n++;
    end
    return mkf(n > 2 ? 3 : n, lo, hi);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_ptr = 0; m_bits = 0; m_rpt = '0; m_sr = '0;
      m_ready = 1'b0; m_cd = 1'b1; m_kd = 1'b0;
      for (int i = 0; i < NP; i++) m_ref[i] = '0;
    end else begin
      bit crise, cfall, krise, kfall, ohold, oready;
      logic [31:0] orpt;
      logic [PW-1:0] cur;
      crise = m_c2 && !m_cd; cfall = !m_c2 && m_cd;
      krise = m_k2 && !m_kd; kfall = !m_k2 && m_kd;
      ohold = (m_state == 2); orpt = m_rpt; oready = m_ready;
      m_ready = crise && (m_bits == 32) && ohold;
      if (cfall) begin
        m_sr = ohold ? orpt : '0; m_bits = 0;
      end else if (!m_c2) begin
        if (krise && m_bits < 32) m_bits++;
        if (kfall) m_sr = m_sr << 1;
      end
      m_cd = m_c2; m_kd = m_k2;
      cur = m_p2[m_ptr*PW +: PW];
      case (m_state)
        0: begin
          m_ref[m_ptr] = cur;
          if (m_ptr == NP-1) m_state = 1;
          m_ptr = (m_ptr + 1) % NP;
        end
        1: begin
          if ((cur ^ m_ref[m_ptr]) != '0) begin
            m_rpt = build(m_ptr, cur ^ m_ref[m_ptr]);
            m_ref[m_ptr] = cur;
            m_state = 2;
          end
          m_ptr = (m_ptr + 1) % NP;
        end
        default: if (oready) m_state = 1;
      endcase
    end
    m_c2 = m_c1; m_c1 = cs_n; m_k2 = m_k1; m_k1 = sclk;
    m_p2 = m_p1; m_p1 = pins;
  end

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n) begin
    check(irq === (m_state == 2), "R5 irq vs model", 32'(irq), 32'(m_state == 2));
    check(miso === (m_c2 ? 1'b0 : m_sr[31]), "R8 miso vs model",
          32'(miso), 32'(m_c2 ? 1'b0 : m_sr[31]));
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic spi_read(input int nbits, output logic [31:0] got);
    got = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      got = {got[30:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 40 && !irq; i++) @(negedge clk);
  endtask

  task automatic flip(input int idx);
    @(negedge clk) pins[idx] = ~pins[idx];
  endtask

  logic [31:0] f;

  initial begin
    pins = 48'h1234_A5A5_0F0F;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and no report for levels present at reset
    check(irq === 1'b0 && miso === 1'b0, "R1 reset outputs", {30'b0, irq, miso}, 32'h0);
    repeat (30) @(negedge clk);
    check(irq === 1'b0, "R1 no report after priming", 32'(irq), 32'h0);

    // R7 read with nothing pending
    spi_read(32, f);
    check(f === 32'h0, "R7 empty frame", f, 32'h0);
    check(irq === 1'b0, "R7 irq unaffected", 32'(irq), 32'h0);

    // R2 R3 R4 single change on port 1 bit 5
    flip(21); wait_irq();
    check(irq === 1'b1, "R2 irq on change", 32'(irq), 32'h1);
    spi_read(32, f);
    check(f === mkf(1, 21, 0), "R3 R4 single", f, mkf(1, 21, 0));
    repeat (6) @(negedge clk);
    check(irq === 1'b0, "R6 irq cleared", 32'(irq), 32'h0);

    // R4 two changes on port 2
    @(negedge clk) begin pins[35] = ~pins[35]; pins[41] = ~pins[41]; end
    wait_irq(); spi_read(32, f);
    check(f === mkf(2, 35, 41), "R4 double", f, mkf(2, 35, 41));

    // R4 three changes on port 0
    @(negedge clk) begin pins[1] = ~pins[1]; pins[2] = ~pins[2]; pins[7] = ~pins[7]; end
    wait_irq(); spi_read(32, f);
    check(f === mkf(3, 1, 2), "R4 more than two", f, mkf(3, 1, 2));

    // R6 aborted read
    flip(28); wait_irq();
    spi_read(16, f);
    repeat (6) @(negedge clk);
    check(irq === 1'b1, "R6 abort keeps irq", 32'(irq), 32'h1);
    spi_read(32, f);
    check(f === mkf(1, 28, 0), "R6 reread frame", f, mkf(1, 28, 0));
    repeat (6) @(negedge clk);
    check(irq === 1'b0, "R6 irq cleared after full read", 32'(irq), 32'h0);

    // R5 change during wait is held back then reported
    flip(0); wait_irq();
    flip(47);
    repeat (20) @(negedge clk);
    spi_read(32, f);
    check(f === mkf(1, 0, 0), "R5 first report", f, mkf(1, 0, 0));
    wait_irq();
    check(irq === 1'b1, "R5 queued change raises irq", 32'(irq), 32'h1);
    spi_read(32, f);
    check(f === mkf(1, 47, 0), "R5 queued report", f, mkf(1, 47, 0));

    // R9 pin returning to its earlier level
    flip(21); wait_irq();
    spi_read(32, f);
    check(f === mkf(1, 21, 0), "R9 revert reported", f, mkf(1, 21, 0));
    repeat (30) @(negedge clk);
    check(irq === 1'b0, "R9 quiet after revert", 32'(irq), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule